// File: doc/BRIEF.md
# Two-Channel DMA Bus Arbiter

This block owns the decision of who drives a shared system bus in each cycle: the processor or one of two DMA channels. Each channel is set either to burst operation, where it keeps the bus for unit after unit, or to cycle-steal operation, where it hands the bus back after every unit. A single mode input selects how the channels are ranked. In fixed ranking, channel 0 always wins. In round-robin ranking, the two channels take turns one transfer unit at a time.

The surrounding DMA engine does the counting and the data movement. It reports the end of every transfer unit with `unit_done`, and it flags the final unit of a block with `blk_done`. The arbiter only moves ownership at those unit boundaries, so a bus cycle is never cut in half. When the bus passes to a channel, it marks the first cycle of each granted unit with `cyc_start`. When the processor owns the bus, every cycle counts as a boundary, so a waiting channel is granted on the next edge.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset the grant is `gnt = 3'b001` (bit 0 processor, bit 1 channel 0, bit 2 channel 1) and `cyc_start` is 0.
- R2: With no channel request, the processor is granted at the next boundary. The processor owning the bus, or `unit_done` being high, makes a boundary.
- R3: While a channel owns the bus, `gnt` keeps its value in every cycle that follows a cycle without `unit_done`.
- R4: If channel 0 requests while channel 1 is bursting, channel 0 owns the bus right after the next `unit_done`. It does not wait for the end of channel 1's block.
- R5: In fixed ranking (`rr_mode = 0`), channel 1 gets the bus back only after the boundary at which channel 0 signals `blk_done[0]`. This holds for both of channel 0's operating modes.
- R6: In round-robin ranking with both channels eligible, each `unit_done` hands the bus to the other channel. The order is channel 1, channel 0, channel 1, and so on.
- R7: While a channel with `burst_mode[i] = 1` has an eligible request, the processor is not granted.
- R8: A channel with `burst_mode[i] = 0` that is the only DMA requester gives the bus to the processor for one cycle after each unit. It then regains the bus.
- R9: After reset, the round-robin turn favours channel 0 when both channels first request together.
- R10: Exactly one bit of `gnt` is high in every cycle.
- R11: `cyc_start` is high exactly in the first cycle of each unit granted to a channel, and low while the processor owns the bus.
- R12: At a boundary where the owning channel raises `blk_done`, that channel is not eligible, even if its request is still high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 2 | Request level per channel |
| burst_mode | input | 2 | Per channel: 1 burst, 0 cycle steal |
| rr_mode | input | 1 | 1 round-robin ranking, 0 fixed ranking with channel 0 first |
| unit_done | input | 1 | Current channel unit ends in this cycle |
| blk_done | input | 2 | Per channel: the unit ending now is the last of its block |
| gnt | output | 3 | One-hot grant: bit 0 processor, bit 1 channel 0, bit 2 channel 1 |
| cyc_start | output | 1 | First cycle of a unit granted to a channel |

## Verification
The directed cases check the main function against one kind of traffic each:
- A lone bursting channel shows the hold and the processor lockout.
- Channel 0 arriving in the middle of channel 1's burst, in fixed ranking, shows the preemption at the unit boundary and the wait for channel 0's block end.
- Two bursting channels in round-robin ranking show the alternation and the reset turn.
- A lone cycle-steal channel shows the one-cycle processor windows.
- A burst ended by `blk_done` while the request is still high separates "block done" from "request dropped".

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int NCH = 2;

  typedef enum logic [1:0] {
    OWN_CPU = 2'd0,
    OWN_CH0 = 2'd1,
    OWN_CH1 = 2'd2
  } owner_e;

  // Channel index to owner code.
  function automatic owner_e f_ch_owner(input logic ch);
    return ch ? OWN_CH1 : OWN_CH0;
  endfunction

  // Choose a channel from a non-empty eligible set.
  // Fixed ranking: channel 0 first. Round robin: not the last one served.
  function automatic owner_e f_pick(input logic [NCH-1:0] elig,
                                    input logic rr,
                                    input logic last_ch1);
    if (elig == 2'b11) begin
      if (rr) return f_ch_owner(!last_ch1);
      return OWN_CH0;
    end
    return elig[0] ? OWN_CH0 : OWN_CH1;
  endfunction

  // Owner code to one-hot grant {ch1, ch0, cpu}.
  function automatic logic [NCH:0] f_onehot(input owner_e o);
    logic [NCH:0] v;
    v = '0;
    case (o)
      OWN_CH0: v[1] = 1'b1;
      OWN_CH1: v[2] = 1'b1;
      default: v[0] = 1'b1;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/dma_arb_elig.sv
module dma_arb_elig
  import dma_arb_pkg::*;
(
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] burst_mode,
  input  logic           unit_done,
  input  logic [NCH-1:0] blk_done,
  input  owner_e         owner,
  output logic [NCH-1:0] elig,
  output logic           burst_lock
);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic own_i;
    assign own_i   = (owner == f_ch_owner(i[0]));
    // A channel finishing its block at this boundary drops out.
    assign elig[i] = req[i] & ~(unit_done & blk_done[i] & own_i);
  end

  assign burst_lock = |(elig & burst_mode);

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
(
  input  owner_e         owner,
  input  logic           unit_done,
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] burst_mode,
  input  logic           burst_lock,
  input  logic           rr_mode,
  input  logic           rr_last_ch1,
  output logic           boundary,
  output owner_e         next_owner
);

  logic cur_steal;

  assign boundary = (owner == OWN_CPU) | unit_done;

  always_comb begin
    case (owner)
      OWN_CH0: cur_steal = ~burst_mode[0];
      OWN_CH1: cur_steal = ~burst_mode[1];
      default: cur_steal = 1'b0;
    endcase
  end

  always_comb begin
    if (!boundary)
      next_owner = owner;
    else if (elig == '0)
      next_owner = OWN_CPU;
    else if (cur_steal && !burst_lock)
      next_owner = OWN_CPU;
    else
      next_owner = f_pick(elig, rr_mode, rr_last_ch1);
  end

endmodule

// File: rtl/dma_arb_rr_ptr.sv
module dma_arb_rr_ptr
  import dma_arb_pkg::*;
#(
  parameter logic RESET_LAST_CH1 = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   boundary,
  input  owner_e next_owner,
  output logic   last_ch1
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      last_ch1 <= RESET_LAST_CH1;
    else if (boundary && next_owner != OWN_CPU)
      last_ch1 <= (next_owner == OWN_CH1);
  end

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter logic RESET_LAST_CH1 = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] burst_mode,
  input  logic       rr_mode,
  input  logic       unit_done,
  input  logic [1:0] blk_done,
  output logic [2:0] gnt,
  output logic       cyc_start
);

  owner_e         owner_q;
  owner_e         next_owner;
  logic [NCH-1:0] elig;
  logic           burst_lock;
  logic           boundary;
  logic           rr_last_ch1;
  logic           cs_q;

  dma_arb_elig u_elig (
    .req        (req),
    .burst_mode (burst_mode),
    .unit_done  (unit_done),
    .blk_done   (blk_done),
    .owner      (owner_q),
    .elig       (elig),
    .burst_lock (burst_lock)
  );

  dma_arb_pick u_pick (
    .owner       (owner_q),
    .unit_done   (unit_done),
    .elig        (elig),
    .burst_mode  (burst_mode),
    .burst_lock  (burst_lock),
    .rr_mode     (rr_mode),
    .rr_last_ch1 (rr_last_ch1),
    .boundary    (boundary),
    .next_owner  (next_owner)
  );

  dma_arb_rr_ptr #(.RESET_LAST_CH1(RESET_LAST_CH1)) u_rr (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .next_owner (next_owner),
    .last_ch1   (rr_last_ch1)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_CPU;
      cs_q    <= 1'b0;
    end else begin
      owner_q <= next_owner;
      cs_q    <= boundary && (next_owner != OWN_CPU);
    end
  end

  assign gnt       = f_onehot(owner_q);
  assign cyc_start = cs_q;

endmodule

// File: rtl/dma_bus_arbiter_chk.sv
module dma_bus_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] req,
  input logic [1:0] burst_mode,
  input logic       rr_mode,
  input logic       unit_done,
  input logic [1:0] blk_done,
  input logic [2:0] gnt,
  input logic       cyc_start,
  input logic       burst_lock
);

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt) == 1);

  p_idle_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt[0] || unit_done) && req == 2'b00) |=> gnt[0]);

  p_hold_unit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt[0] && !unit_done) |=> $stable(gnt));

  p_cpu_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_lock |=> !gnt[0]);

  p_steal_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (((gnt[1] && !burst_mode[0]) || (gnt[2] && !burst_mode[1]))
      && unit_done && !burst_lock) |=> gnt[0]);

  p_rr_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_mode && gnt[1] && unit_done && req == 2'b11 && blk_done == 2'b00
      && burst_lock) |=> gnt[2]);

  p_start_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> !gnt[0]);

  p_start_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt[0] && !$stable(gnt)) |-> cyc_start);

endmodule

bind dma_bus_arbiter dma_bus_arbiter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .burst_mode (burst_mode),
  .rr_mode    (rr_mode),
  .unit_done  (unit_done),
  .blk_done   (blk_done),
  .gnt        (gnt),
  .cyc_start  (cyc_start),
  .burst_lock (burst_lock)
);

// File: tb/dma_bus_arbiter_tb.sv
`timescale 1ns/1ps
module dma_bus_arbiter_tb;

  localparam logic [2:0] G_CPU = 3'b001;
  localparam logic [2:0] G_C0  = 3'b010;
  localparam logic [2:0] G_C1  = 3'b100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] req;
  logic [1:0] burst_mode;
  logic       rr_mode;
  logic       unit_done;
  logic [1:0] blk_done;
  logic [2:0] gnt;
  logic       cyc_start;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .burst_mode (burst_mode),
    .rr_mode    (rr_mode),
    .unit_done  (unit_done),
    .blk_done   (blk_done),
    .gnt        (gnt),
    .cyc_start  (cyc_start)
  );

  task automatic chk(input string tag, input logic [2:0] eg, input logic ecs);
    checks++;
    if (gnt !== eg || cyc_start !== ecs) begin
      failures++;
      $display("FAIL %s: gnt=%b cyc_start=%b expected gnt=%b cyc_start=%b",
               tag, gnt, cyc_start, eg, ecs);
    end
    checks++;
    if ($countones(gnt) != 1) begin
      failures++;
      $display("FAIL R10: gnt=%b expected one-hot", gnt);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check 1 ns later,
  // return at the next falling edge.
  task automatic cyc(input logic [1:0] r, input logic [1:0] bm, input logic rr,
                     input logic ud, input logic [1:0] bd,
                     input logic [2:0] eg, input logic ecs, input string tag);
    req = r; burst_mode = bm; rr_mode = rr; unit_done = ud; blk_done = bd;
    @(posedge clk);
    #1;
    chk(tag, eg, ecs);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; burst_mode = '0; rr_mode = 1'b0;
    unit_done = 1'b0; blk_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset state", G_CPU, 1'b0);
  endtask

  task automatic t_idle();
    do_reset();
    cyc(2'b00, 2'b11, 1'b0, 1'b0, 2'b00, G_CPU, 1'b0, "R2 idle");
    cyc(2'b00, 2'b00, 1'b1, 1'b1, 2'b00, G_CPU, 1'b0, "R2 idle stray unit_done");
  endtask

  task automatic t_fixed_preempt();
    do_reset();
    cyc(2'b10, 2'b10, 1'b0, 1'b0, 2'b00, G_C1, 1'b1, "R11 ch1 burst starts");
    cyc(2'b10, 2'b10, 1'b0, 1'b0, 2'b00, G_C1, 1'b0, "R3 hold mid unit");
    cyc(2'b10, 2'b10, 1'b0, 1'b1, 2'b00, G_C1, 1'b1, "R7 burst keeps bus");
    cyc(2'b10, 2'b10, 1'b0, 1'b1, 2'b00, G_C1, 1'b1, "R7 burst keeps bus again");
    cyc(2'b11, 2'b10, 1'b0, 1'b0, 2'b00, G_C1, 1'b0, "R3 no switch mid unit");
    cyc(2'b11, 2'b10, 1'b0, 1'b1, 2'b00, G_C0, 1'b1, "R4 ch0 preempts burst");
    cyc(2'b11, 2'b10, 1'b0, 1'b1, 2'b00, G_C0, 1'b1, "R5 steal ch0 keeps bus in fixed");
    cyc(2'b11, 2'b10, 1'b0, 1'b1, 2'b01, G_C1, 1'b1, "R5 ch1 resumes after block");
    cyc(2'b10, 2'b10, 1'b0, 1'b1, 2'b00, G_C1, 1'b1, "R7 ch1 continues");
  endtask

  task automatic t_round_robin();
    do_reset();
    cyc(2'b11, 2'b11, 1'b1, 1'b0, 2'b00, G_C0, 1'b1, "R9 reset turn to ch0");
    cyc(2'b11, 2'b11, 1'b1, 1'b1, 2'b00, G_C1, 1'b1, "R6 alternate to ch1");
    cyc(2'b11, 2'b11, 1'b1, 1'b1, 2'b00, G_C0, 1'b1, "R6 alternate to ch0");
    cyc(2'b11, 2'b11, 1'b1, 1'b0, 2'b00, G_C0, 1'b0, "R3 hold in rr");
    cyc(2'b11, 2'b11, 1'b1, 1'b1, 2'b00, G_C1, 1'b1, "R6 alternate to ch1 again");
  endtask

  task automatic t_steal();
    do_reset();
    cyc(2'b01, 2'b00, 1'b0, 1'b0, 2'b00, G_C0, 1'b1, "R8 steal grant");
    cyc(2'b01, 2'b00, 1'b0, 1'b1, 2'b00, G_CPU, 1'b0, "R8 release to cpu");
    cyc(2'b01, 2'b00, 1'b0, 1'b0, 2'b00, G_C0, 1'b1, "R8 regain after one cycle");
    cyc(2'b01, 2'b00, 1'b0, 1'b1, 2'b00, G_CPU, 1'b0, "R8 release again");
  endtask

  task automatic t_block_end();
    do_reset();
    cyc(2'b01, 2'b01, 1'b0, 1'b0, 2'b00, G_C0, 1'b1, "R11 ch0 burst starts");
    cyc(2'b01, 2'b01, 1'b0, 1'b1, 2'b00, G_C0, 1'b1, "R7 ch0 burst continues");
    cyc(2'b01, 2'b01, 1'b0, 1'b1, 2'b01, G_CPU, 1'b0, "R12 block done with req high");
    cyc(2'b00, 2'b01, 1'b0, 1'b0, 2'b00, G_CPU, 1'b0, "R2 idle after block");
  endtask

  initial begin
    @(negedge clk);
    t_idle();
    t_fixed_preempt();
    t_round_robin();
    t_steal();
    t_block_end();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule